// File: doc/BRIEF.md
# Data Link Interrupt Status Register

This block gathers the event pulses of a serial data-link receiver into sticky status bits. Three sources feed it: a frame check failure, an abort sequence and an idle flag. It also records whether the most recent completed frame was message-oriented or bit-oriented. Each source has its own enable bit. A single-bit block enable sits above those enables. One registered interrupt line goes high while any enabled source has its status bit set and the block enable is on.

Software reaches the block through a small synchronous register bus. Read data is combinational during a read cycle. Any register side effect takes place at the clock edge that ends the cycle. A control bit chooses how the status register is cleared. In clear-on-read mode, reading the status register clears the source bits that the read returned. In write-one-to-clear mode, only bits written as 1 are cleared.

Top module: `dl_irq_regs`

## Requirements
- R1: After reset, all four registers read 0x00 and `irq` is 0.
- R2: An event pulse whose source enable is 1 sets its status bit at that clock edge, and the bit stays set until it is cleared. The status bit positions are: bit 0 frame check error, bit 1 abort, bit 2 idle. Register addresses are: 0 status, 1 source enable, 2 control, 3 block enable.
- R3: An event pulse whose source enable bit (same bit position as its status bit) is 0 leaves its status bit unchanged.
- R4: With control bit 0 set to 1 (clear-on-read), a read of the status register returns the current bits and then clears the source bits it returned. In this mode, writes to the status register have no effect.
- R5: With control bit 0 at 0 (write-one-to-clear), reads leave the status bits unchanged. A write to the status register clears exactly the source bits written as 1.
- R6: If an enabled event arrives in the same cycle as a clear of its bit, by either a read or a write, the bit stays set.
- R7: `irq` is registered. It equals the OR of the set status bits whose source enable is 1, as seen one clock earlier. Turning off a source enable drops `irq` without changing status.
- R8: `irq` is 0 whenever block enable bit 0 is 0. The status bits are kept while the block enable is off.
- R9: Status bit 3 is read-only. It takes the value of `frame_mos` (1 = message-oriented) on each cycle with `frame_done` high. It is unaffected by either clear mode.
- R10: The source enable register implements bits 2:0, and the control and block enable registers implement bit 0. Unimplemented bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while a read is selected, else 0 |
| evt_fcs_err | input | 1 | Frame check error pulse |
| evt_abort | input | 1 | Abort sequence pulse |
| evt_idle | input | 1 | Idle flag pulse |
| frame_done | input | 1 | Frame completed strobe |
| frame_mos | input | 1 | Type of completed frame, 1 = message-oriented |
| irq | output | 1 | Registered interrupt |

## Verification
The hardest case to reach is a collision: an enabled event arriving in the very cycle that its status bit is being cleared. The cleared case can be a status read in clear-on-read mode, or a one written in write-one-to-clear mode. The bench drives the event pulse and the bus access on the same falling edge, so both land on one rising edge. It then reads back to confirm the bit survived. The registered interrupt is checked one cycle after each status or enable change. This separates the register delay from the gating.

// File: rtl/dl_irq_pkg.sv
package dl_irq_pkg;
  localparam int unsigned DL_DATA_W  = 8;
  localparam int unsigned DL_ADDR_W  = 2;
  localparam int unsigned DL_NUM_SRC = 3;

  localparam int unsigned SRC_FCS   = 0;
  localparam int unsigned SRC_ABORT = 1;
  localparam int unsigned SRC_IDLE  = 2;

  typedef enum logic [DL_ADDR_W-1:0] {
    REG_STATUS = 2'd0,
    REG_SRC_EN = 2'd1,
    REG_CTRL   = 2'd2,
    REG_BLK_EN = 2'd3
  } dl_reg_e;
endpackage

// File: rtl/dl_irq_bus_decode.sv
module dl_irq_bus_decode
  import dl_irq_pkg::*;
#(
  parameter int unsigned DATA_W  = DL_DATA_W,
  parameter int unsigned NUM_SRC = DL_NUM_SRC
) (
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [DL_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic [NUM_SRC-1:0]   status_q,
  input  logic                 mos_q,
  input  logic [NUM_SRC-1:0]   src_en_q,
  input  logic                 cor_q,
  input  logic                 blk_en_q,
  output logic                 wr_src_en,
  output logic                 wr_ctrl,
  output logic                 wr_blk_en,
  output logic [NUM_SRC-1:0]   clr_mask,
  output logic [DATA_W-1:0]    rdata
);
  dl_reg_e    reg_sel;
  logic       rd_cyc;
  logic       wr_cyc;
  logic       stat_rd;
  logic       stat_wr;
  logic [DATA_W-1:0] stat_view;
  logic [DATA_W-1:0] en_view;
  logic [DATA_W-1:0] ctrl_view;
  logic [DATA_W-1:0] blk_view;

  assign reg_sel = dl_reg_e'(bus_addr);
  assign rd_cyc  = bus_sel && !bus_wr;
  assign wr_cyc  = bus_sel && bus_wr;
  assign stat_rd = rd_cyc && (reg_sel == REG_STATUS);
  assign stat_wr = wr_cyc && (reg_sel == REG_STATUS);

  assign wr_src_en = wr_cyc && (reg_sel == REG_SRC_EN);
  assign wr_ctrl   = wr_cyc && (reg_sel == REG_CTRL);
  assign wr_blk_en = wr_cyc && (reg_sel == REG_BLK_EN);

  always_comb begin
    if (cor_q) begin
      clr_mask = stat_rd ? status_q : '0;
    end else begin
      clr_mask = stat_wr ? bus_wdata[NUM_SRC-1:0] : '0;
    end
  end

  always_comb begin
    stat_view = '0;
    stat_view[NUM_SRC-1:0] = status_q;
    stat_view[NUM_SRC]     = mos_q;
    en_view   = '0;
    en_view[NUM_SRC-1:0] = src_en_q;
    ctrl_view = '0;
    ctrl_view[0] = cor_q;
    blk_view  = '0;
    blk_view[0]  = blk_en_q;
  end

  always_comb begin
    rdata = '0;
    if (rd_cyc) begin
      unique case (reg_sel)
        REG_STATUS: rdata = stat_view;
        REG_SRC_EN: rdata = en_view;
        REG_CTRL:   rdata = ctrl_view;
        REG_BLK_EN: rdata = blk_view;
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dl_irq_sticky_bank.sv
module dl_irq_sticky_bank #(
  parameter int unsigned NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] status_q
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic set_i;
    assign set_i = evt[i] && src_en[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        status_q[i] <= 1'b0;
      end else if (set_i) begin
        status_q[i] <= 1'b1;
      end else if (clr[i]) begin
        status_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dl_irq_reduce.sv
module dl_irq_reduce #(
  parameter int unsigned NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status_q,
  input  logic [NUM_SRC-1:0] src_en_q,
  input  logic               blk_en_q,
  output logic               irq_q
);
  logic pending;
  assign pending = |(status_q & src_en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= blk_en_q && pending;
    end
  end
endmodule

// File: rtl/dl_irq_regs.sv
module dl_irq_regs
  import dl_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [DL_ADDR_W-1:0] bus_addr,
  input  logic [DL_DATA_W-1:0] bus_wdata,
  output logic [DL_DATA_W-1:0] bus_rdata,
  input  logic                 evt_fcs_err,
  input  logic                 evt_abort,
  input  logic                 evt_idle,
  input  logic                 frame_done,
  input  logic                 frame_mos,
  output logic                 irq
);
  localparam int unsigned DATA_W  = DL_DATA_W;
  localparam int unsigned NUM_SRC = DL_NUM_SRC;

  logic [NUM_SRC-1:0] evt_vec;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] src_en_q;
  logic [NUM_SRC-1:0] clr_mask;
  logic               cor_q;
  logic               blk_en_q;
  logic               mos_q;
  logic               wr_src_en;
  logic               wr_ctrl;
  logic               wr_blk_en;
  logic               wdata_unused;

  assign wdata_unused = ^bus_wdata[DATA_W-1:NUM_SRC];

  always_comb begin
    evt_vec = '0;
    evt_vec[SRC_FCS]   = evt_fcs_err;
    evt_vec[SRC_ABORT] = evt_abort;
    evt_vec[SRC_IDLE]  = evt_idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_en_q <= '0;
      cor_q    <= 1'b0;
      blk_en_q <= 1'b0;
      mos_q    <= 1'b0;
    end else begin
      if (wr_src_en) src_en_q <= bus_wdata[NUM_SRC-1:0];
      if (wr_ctrl)   cor_q    <= bus_wdata[0];
      if (wr_blk_en) blk_en_q <= bus_wdata[0];
      if (frame_done) mos_q   <= frame_mos;
    end
  end

  dl_irq_bus_decode #(
    .DATA_W  (DATA_W),
    .NUM_SRC (NUM_SRC)
  ) u_decode (
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .status_q  (status_q),
    .mos_q     (mos_q),
    .src_en_q  (src_en_q),
    .cor_q     (cor_q),
    .blk_en_q  (blk_en_q),
    .wr_src_en (wr_src_en),
    .wr_ctrl   (wr_ctrl),
    .wr_blk_en (wr_blk_en),
    .clr_mask  (clr_mask),
    .rdata     (bus_rdata)
  );

  dl_irq_sticky_bank #(
    .NUM_SRC (NUM_SRC)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_vec),
    .src_en   (src_en_q),
    .clr      (clr_mask),
    .status_q (status_q)
  );

  dl_irq_reduce #(
    .NUM_SRC (NUM_SRC)
  ) u_reduce (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_q (status_q),
    .src_en_q (src_en_q),
    .blk_en_q (blk_en_q),
    .irq_q    (irq)
  );
endmodule

// File: rtl/dl_irq_regs_chk.sv
module dl_irq_regs_chk #(
  parameter int unsigned NUM_SRC = 3,
  parameter int unsigned ADDR_W  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [NUM_SRC-1:0] evt_vec,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] src_en_q,
  input logic               cor_q,
  input logic               blk_en_q,
  input logic               irq
);
  logic stat_access;
  assign stat_access = bus_sel && (bus_addr == '0);

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_vec & src_en_q) != '0) |=> ((status_q & $past(evt_vec & src_en_q)) == $past(evt_vec & src_en_q))); // R6

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_access |=> (($past(status_q) & ~status_q) == '0)); // R2

  AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(src_en_q)) == '0)); // R3

  AST_COR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_q && stat_access && !bus_wr && ((evt_vec & src_en_q) == '0)) |=> (status_q == '0)); // R4

  AST_W1C_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cor_q && stat_access && !bus_wr) |=> (($past(status_q) & ~status_q) == '0)); // R5

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(status_q & src_en_q) != '0)); // R7

  AST_IRQ_NEEDS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_en_q |=> !irq); // R8
endmodule

bind dl_irq_regs dl_irq_regs_chk #(
  .NUM_SRC (dl_irq_pkg::DL_NUM_SRC),
  .ADDR_W  (dl_irq_pkg::DL_ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .evt_vec  (evt_vec),
  .status_q (status_q),
  .src_en_q (src_en_q),
  .cor_q    (cor_q),
  .blk_en_q (blk_en_q),
  .irq      (irq)
);

// File: tb/dl_irq_regs_bench.sv
`timescale 1ns/1ps
module dl_irq_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       evt_fcs_err = 1'b0;
  logic       evt_abort = 1'b0;
  logic       evt_idle = 1'b0;
  logic       frame_done = 1'b0;
  logic       frame_mos = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dl_irq_regs u_dl_irq_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_fcs_err(evt_fcs_err), .evt_abort(evt_abort), .evt_idle(evt_idle),
    .frame_done(frame_done), .frame_mos(frame_mos), .irq(irq)
  );

  localparam logic [1:0] A_STAT = 2'd0, A_EN = 2'd1, A_CTRL = 2'd2, A_BLK = 2'd3;

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pulse_evt(input logic [2:0] v);
    @(negedge clk);
    {evt_idle, evt_abort, evt_fcs_err} = v;
    @(negedge clk);
    {evt_idle, evt_abort, evt_fcs_err} = 3'b000;
  endtask

  task automatic clear_all();
    bus_write(A_CTRL, 8'h00);
    bus_write(A_STAT, 8'hFF);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_read(A_STAT, d); check("R1", "status after reset", d, 8'h00);
    bus_read(A_EN, d);   check("R1", "src enable after reset", d, 8'h00);
    bus_read(A_CTRL, d); check("R1", "control after reset", d, 8'h00);
    bus_read(A_BLK, d);  check("R1", "block enable after reset", d, 8'h00);
    check("R1", "irq after reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_set_hold();
    logic [7:0] d;
    bus_write(A_EN, 8'h07);
    pulse_evt(3'b010);
    bus_read(A_STAT, d); check("R2", "abort sets bit1", d, 8'h02);
    repeat (3) @(negedge clk);
    bus_read(A_STAT, d); check("R2", "abort bit held", d, 8'h02);
    pulse_evt(3'b100);
    bus_read(A_STAT, d); check("R2", "idle sets bit2", d, 8'h06);
    pulse_evt(3'b001);
    bus_read(A_STAT, d); check("R2", "fcs sets bit0", d, 8'h07);
    clear_all();
  endtask

  task automatic t_masked();
    logic [7:0] d;
    bus_write(A_EN, 8'h05);
    pulse_evt(3'b010);
    bus_read(A_STAT, d); check("R3", "masked abort ignored", d, 8'h00);
    pulse_evt(3'b111);
    bus_read(A_STAT, d); check("R3", "only enabled bits set", d, 8'h05);
    clear_all();
    bus_write(A_EN, 8'h07);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    bus_write(A_CTRL, 8'h00);
    pulse_evt(3'b111);
    bus_read(A_STAT, d); check("R5", "w1c read returns bits", d, 8'h07);
    bus_read(A_STAT, d); check("R5", "w1c read does not clear", d, 8'h07);
    bus_write(A_STAT, 8'h02);
    bus_read(A_STAT, d); check("R5", "write 1 clears bit1 only", d, 8'h05);
    bus_write(A_STAT, 8'h00);
    bus_read(A_STAT, d); check("R5", "write 0 clears nothing", d, 8'h05);
    bus_write(A_STAT, 8'h05);
    bus_read(A_STAT, d); check("R5", "remaining bits cleared", d, 8'h00);
  endtask

  task automatic t_cor();
    logic [7:0] d;
    bus_write(A_CTRL, 8'h01);
    pulse_evt(3'b111);
    bus_write(A_STAT, 8'h07);
    bus_read(A_STAT, d); check("R4", "cor write ignored, read returns", d, 8'h07);
    bus_read(A_STAT, d); check("R4", "cor read cleared bits", d, 8'h00);
    pulse_evt(3'b100);
    bus_read(A_STAT, d); check("R4", "cor second set returns", d, 8'h04);
    bus_read(A_STAT, d); check("R4", "cor second read clear", d, 8'h00);
    bus_write(A_CTRL, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    bus_write(A_CTRL, 8'h01);
    pulse_evt(3'b001);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_STAT; evt_fcs_err = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; evt_fcs_err = 1'b0;
    check("R6", "cor collision read value", d, 8'h01);
    bus_read(A_STAT, d); check("R6", "event beats clear-on-read", d, 8'h01);
    bus_write(A_CTRL, 8'h00);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 8'h01; evt_fcs_err = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; evt_fcs_err = 1'b0;
    bus_read(A_STAT, d); check("R6", "event beats write-one-to-clear", d, 8'h01);
    clear_all();
  endtask

  task automatic t_irq();
    logic [7:0] d;
    bus_write(A_EN, 8'h07);
    bus_write(A_BLK, 8'h01);
    check("R7", "irq low with no status", {7'd0, irq}, 8'h00);
    pulse_evt(3'b010);
    check("R7", "irq not yet set (registered)", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R7", "irq set one cycle later", {7'd0, irq}, 8'h01);
    bus_write(A_EN, 8'h05);
    @(negedge clk);
    check("R7", "irq drops with source disabled", {7'd0, irq}, 8'h00);
    bus_read(A_STAT, d); check("R7", "status kept with source disabled", d, 8'h02);
    bus_write(A_EN, 8'h07);
    @(negedge clk);
    check("R7", "irq back with source enabled", {7'd0, irq}, 8'h01);
    bus_write(A_BLK, 8'h00);
    @(negedge clk);
    check("R8", "irq low with block disabled", {7'd0, irq}, 8'h00);
    bus_read(A_STAT, d); check("R8", "status kept with block disabled", d, 8'h02);
    bus_write(A_BLK, 8'h01);
    @(negedge clk);
    check("R8", "irq back with block enabled", {7'd0, irq}, 8'h01);
    bus_write(A_STAT, 8'h02);
    @(negedge clk);
    check("R7", "irq low after clear", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_msg();
    logic [7:0] d;
    @(negedge clk); frame_mos = 1'b1; frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
    bus_read(A_STAT, d); check("R9", "mos frame sets bit3", d, 8'h08);
    bus_write(A_STAT, 8'hFF);
    bus_read(A_STAT, d); check("R9", "bit3 survives w1c", d, 8'h08);
    bus_write(A_CTRL, 8'h01);
    bus_read(A_STAT, d);
    bus_read(A_STAT, d); check("R9", "bit3 survives cor", d, 8'h08);
    bus_write(A_CTRL, 8'h00);
    @(negedge clk); frame_mos = 1'b0;
    @(negedge clk);
    bus_read(A_STAT, d); check("R9", "no frame_done no change", d, 8'h08);
    @(negedge clk); frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
    bus_read(A_STAT, d); check("R9", "bit-oriented frame clears bit3", d, 8'h00);
  endtask

  task automatic t_cfg();
    logic [7:0] d;
    bus_write(A_EN, 8'hFF);   bus_read(A_EN, d);   check("R10", "src enable mask", d, 8'h07);
    bus_write(A_CTRL, 8'hFF); bus_read(A_CTRL, d); check("R10", "control mask", d, 8'h01);
    bus_write(A_BLK, 8'hFE);  bus_read(A_BLK, d);  check("R10", "block enable mask", d, 8'h00);
    bus_write(A_CTRL, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_set_hold();
    t_masked();
    t_w1c();
    t_cor();
    t_collision();
    t_irq();
    t_msg();
    t_cfg();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule